// File: doc/BRIEF.md
# Source-Routed Wormhole Packet Switch

This block is a four-port switch for flit-based traffic. Each packet opens with a head flit whose payload holds the whole path as a chain of 2-bit output-port numbers, one per hop, with the current hop in the least significant bits. The switch has no lookup tables. It reads the lowest field of a waiting head flit and asks the matching output for a grant. When the head leaves, its payload is shifted right by the field width. The next switch on the path therefore sees its own field at the bottom.

The output commits to a path as soon as the head flit is forwarded. Body flits and the closing tail flit from the same input then pass through that output. No other input can use the output until the tail has gone. If an output is taken or its receiver is not ready, the packet waits where it is. Each input holds exactly one flit, and backpressure then reaches the sender through the input's ready signal. Nothing is dropped. When several heads want the same free output, a round-robin pointer for that output picks the winner. After each grant the pointer moves to the input just past the winner.

Every link uses a valid/ready handshake. A flit moves on a clock edge where both valid and ready are high. A flit accepted at an input can leave at an output one cycle later.

Top module: `wh_switch`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A head flit (kind 2'b01, flit bits [18:17]) accepted on any input is offered on the output numbered by payload bits [1:0], in the cycle after it is accepted. It appears on no other output.
- R3: A forwarded head flit has its 16-bit payload shifted right by 2 with zeros filled in at the top. Its kind and last bit (flit bit 16) are unchanged.
- R4: Body (2'b10) and tail (2'b11) flits leave on the same output as their packet's head, and their payload is not modified.
- R5: Once a multi-flit head is forwarded, its output carries no head flit from any input until that packet's tail has been sent.
- R6: A head flit with the last bit set is a complete packet. Its output is free to grant another input in the very next cycle.
- R7: When several heads compete for a free output, the output grants them in rotating order, starting from the input just after the previous winner. After reset the search starts at input 0.
- R8: While `out_valid` is high and `out_ready` is low, the output holds the same flit. The input holding it drops `in_ready`, and no flit is lost.
- R9: An idle flit (kind 2'b00) is accepted at an input, does not occupy the input buffer and never appears on an output.
- R10: Packets from different inputs to different outputs are forwarded in the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-input flit valid |
| in_ready | output | NPORT | Per-input flit ready |
| in_flit | input | NPORT*19 | Input flits; input i at bits [i*19 +: 19] as {kind[1:0], last, payload[15:0]} |
| out_valid | output | NPORT | Per-output flit valid |
| out_ready | input | NPORT | Per-output flit ready |
| out_flit | output | NPORT*19 | Output flits, same layout as the inputs |

## Verification
The hardest situation to reach is a true contention round in which the grant order shows the rotating pointer and not a fixed priority. Four heads must wait at once on a single output, and the pointer must first be moved to a position where round-robin and fixed priority disagree. The bench creates this by holding `out_ready` low while several inputs each load a single-flit head for output 0. It then sends one head from input 2 alone, which moves the pointer to input 3. Next it lets inputs 0 and 3 contend, and expects input 3 to win. The same held-back round is used to show that the stalled flit stays stable and that the stalled input stops accepting flits.

// File: rtl/wh_pkg.sv
package wh_pkg;

    localparam int PAYLOAD_W = 16;

    typedef enum logic [1:0] {
        FT_IDLE = 2'b00,
        FT_HEAD = 2'b01,
        FT_BODY = 2'b10,
        FT_TAIL = 2'b11
    } ftype_e;

    typedef struct packed {
        ftype_e                 kind;
        logic                   last;
        logic [PAYLOAD_W-1:0]   data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    // A flit that closes its packet frees the output it used.
    function automatic logic ends_packet(flit_t f);
        return (f.kind == FT_TAIL) || ((f.kind == FT_HEAD) && f.last);
    endfunction

    // Drop the consumed hop field from a head flit.
    function automatic flit_t advance_route(flit_t f, int unsigned w);
        flit_t r;
        r = f;
        if (f.kind == FT_HEAD) begin
            r.data = f.data >> w;
        end
        return r;
    endfunction

endpackage

// File: rtl/wh_in_slot.sv
module wh_in_slot
    import wh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push_valid,
    output logic  push_ready,
    input  flit_t push_flit,
    input  logic  pop,
    output logic  full,
    output flit_t held_flit
);

    logic  full_q;
    flit_t data_q;

    // Space exists if empty, or if the held flit leaves this cycle.
    assign push_ready = !full_q || pop;
    assign full       = full_q;
    assign held_flit  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (push_valid && push_ready && (push_flit.kind != FT_IDLE)) begin
            full_q <= 1'b1;
            data_q <= push_flit;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc #(
    parameter  int NPORT = 4,
    localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] full,
    input  logic [NPORT-1:0] ends,
    input  logic             out_ready,
    output logic [SEL_W-1:0] sel,
    output logic             grant_valid,
    output logic             xfer
);

    logic             locked_q;
    logic [SEL_W-1:0] owner_q;
    logic [SEL_W-1:0] ptr_q;
    logic             hold_q;
    logic [SEL_W-1:0] hold_sel_q;

    logic             found;
    logic [SEL_W-1:0] pick;
    int               idx;

    // Rotating search beginning at the pointer.
    always_comb begin
        found = 1'b0;
        pick  = ptr_q;
        idx   = 0;
        for (int k = 0; k < NPORT; k++) begin
            idx = (int'(ptr_q) + k) % NPORT;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = SEL_W'(idx);
            end
        end
    end

    // Locked path first, then a stalled offer, then a fresh choice.
    always_comb begin
        if (locked_q) begin
            sel         = owner_q;
            grant_valid = full[owner_q];
        end else if (hold_q) begin
            sel         = hold_sel_q;
            grant_valid = req[hold_sel_q];
        end else begin
            sel         = pick;
            grant_valid = found;
        end
    end

    assign xfer = grant_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q   <= 1'b0;
            owner_q    <= '0;
            ptr_q      <= '0;
            hold_q     <= 1'b0;
            hold_sel_q <= '0;
        end else begin
            hold_q     <= grant_valid && !out_ready;
            hold_sel_q <= sel;
            if (xfer) begin
                if (!locked_q) begin
                    ptr_q <= (sel == SEL_W'(NPORT - 1)) ? '0 : sel + 1'b1;
                end
                if (ends[sel]) begin
                    locked_q <= 1'b0;
                end else if (!locked_q) begin
                    locked_q <= 1'b1;
                    owner_q  <= sel;
                end
            end
        end
    end

endmodule

// File: rtl/wh_switch.sv
module wh_switch
    import wh_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int FW    = FLIT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    in_valid,
    output logic [NPORT-1:0]    in_ready,
    input  logic [NPORT*FW-1:0] in_flit,
    output logic [NPORT-1:0]    out_valid,
    input  logic [NPORT-1:0]    out_ready,
    output logic [NPORT*FW-1:0] out_flit
);

    flit_t            slot_flit [NPORT];
    logic [NPORT-1:0] slot_full;
    logic [NPORT-1:0] slot_ends;
    logic [NPORT-1:0] slot_pop;
    logic [NPORT-1:0] req [NPORT];
    logic [SEL_W-1:0] sel [NPORT];
    logic [NPORT-1:0] xfer;

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_in
            wh_in_slot u_slot (
                .clk        (clk),
                .rst        (rst),
                .push_valid (in_valid[i]),
                .push_ready (in_ready[i]),
                .push_flit  (flit_t'(in_flit[i*FW +: FW])),
                .pop        (slot_pop[i]),
                .full       (slot_full[i]),
                .held_flit  (slot_flit[i])
            );
            assign slot_ends[i] = ends_packet(slot_flit[i]);
        end
    endgenerate

    // A waiting head asks for the output named in its lowest field.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req[o][i] = slot_full[i] && (slot_flit[i].kind == FT_HEAD)
                            && (slot_flit[i].data[SEL_W-1:0] == SEL_W'(o));
            end
        end
    end

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_out
            wh_out_alloc #(.NPORT(NPORT)) u_alloc (
                .clk         (clk),
                .rst         (rst),
                .req         (req[o]),
                .full        (slot_full),
                .ends        (slot_ends),
                .out_ready   (out_ready[o]),
                .sel         (sel[o]),
                .grant_valid (out_valid[o]),
                .xfer        (xfer[o])
            );
            assign out_flit[o*FW +: FW] = advance_route(slot_flit[sel[o]], SEL_W);
        end
    endgenerate

    always_comb begin
        slot_pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (xfer[o]) begin
                slot_pop[sel[o]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wh_switch_chk.sv
module wh_switch_chk
    import wh_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int FW    = FLIT_W
) (
    input logic                clk,
    input logic                rst,
    input logic [NPORT-1:0]    out_valid,
    input logic [NPORT-1:0]    out_ready,
    input logic [NPORT*FW-1:0] out_flit
);

    logic rst_d_q;
    always_ff @(posedge clk) rst_d_q <= rst;

    always @(negedge clk) begin
        if (rst_d_q) begin
            AST_RESET_QUIET: assert (out_valid == '0) else $error("outputs active after reset"); // R1
        end
    end

    generate
        for (genvar o = 0; o < NPORT; o++) begin : g_chk
            flit_t f;
            logic  open_q;
            assign f = flit_t'(out_flit[o*FW +: FW]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q <= 1'b0;
                end else if (out_valid[o] && out_ready[o]) begin
                    if (f.kind == FT_HEAD) open_q <= !f.last;
                    else if (f.kind == FT_BODY) open_q <= open_q;
                    else open_q <= 1'b0;
                end
            end

            AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(f)); // R8
            AST_NO_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] |-> f.kind != FT_IDLE); // R9
            AST_ROUTE_STRIPPED: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] && (f.kind == FT_HEAD) |-> f.data[PAYLOAD_W-1 -: SEL_W] == '0); // R3
            AST_HEAD_OPENS: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] && !open_q |-> f.kind == FT_HEAD); // R4
            AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] && open_q |-> f.kind != FT_HEAD); // R5
        end
    endgenerate

endmodule

bind wh_switch wh_switch_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit)
);

// File: tb/wh_switch_bench.sv
module wh_switch_bench;
    import wh_pkg::*;

    localparam int NP = 4;
    localparam int FW = FLIT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          vld   [NP];
    logic [FW-1:0] fl    [NP];
    logic          rdy_o [NP];

    logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready;
    logic [NP*FW-1:0] in_flit, out_flit;

    generate
        for (genvar i = 0; i < NP; i++) begin : g_drv
            assign in_valid[i]          = vld[i];
            assign in_flit[i*FW +: FW]  = fl[i];
            assign out_ready[i]         = rdy_o[i];
        end
    endgenerate

    wh_switch #(.NPORT(NP)) u_wh_switch (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [FW-1:0] rec [NP][32];
    int            cnt [NP];

    // Output monitor, sampling mid low phase.
    initial begin
        for (int o = 0; o < NP; o++) cnt[o] = 0;
        forever begin
            @(negedge clk);
            #5;
            for (int o = 0; o < NP; o++) begin
                if (!rst && out_valid[o] && out_ready[o]) begin
                    if (cnt[o] < 32) rec[o][cnt[o]] = out_flit[o*FW +: FW];
                    cnt[o]++;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(ftype_e k, logic l, logic [PAYLOAD_W-1:0] d);
        flit_t f;
        f.kind = k;
        f.last = l;
        f.data = d;
        return f;
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rec();
        for (int o = 0; o < NP; o++) cnt[o] = 0;
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic put(int p, logic [FW-1:0] f);
        logic ok;
        vld[p] = 1'b1;
        fl[p]  = f;
        do begin
            #5;
            ok = in_ready[p];
            @(negedge clk);
        end while (!ok);
        vld[p] = 1'b0;
    endtask

    task automatic t_reset();
        #5;
        chk("R1 out_valid", 32'(out_valid), 32'h0);
        chk("R1 in_ready", 32'(in_ready), 32'hF);
        @(negedge clk);
    endtask

    task automatic t_basic();
        clear_rec();
        put(0, mk(FT_HEAD, 1'b0, 16'hABC6));
        put(0, mk(FT_BODY, 1'b0, 16'h1234));
        put(0, mk(FT_TAIL, 1'b0, 16'h5678));
        wait_cyc(4);
        chk("R2 count on port 2", 32'(cnt[2]), 32'd3);
        chk("R2 no stray output", 32'(cnt[0] + cnt[1] + cnt[3]), 32'd0);
        chk("R3 head stripped", 32'(rec[2][0]), 32'(mk(FT_HEAD, 1'b0, 16'hABC6 >> 2)));
        chk("R4 body intact", 32'(rec[2][1]), 32'(mk(FT_BODY, 1'b0, 16'h1234)));
        chk("R4 tail intact", 32'(rec[2][2]), 32'(mk(FT_TAIL, 1'b0, 16'h5678)));
    endtask

    task automatic t_single();
        clear_rec();
        fork
            put(1, mk(FT_HEAD, 1'b1, 16'h0007));
            put(2, mk(FT_HEAD, 1'b1, 16'h00FB));
        join
        put(3, mk(FT_HEAD, 1'b1, 16'h0013));
        wait_cyc(4);
        chk("R6 count", 32'(cnt[3]), 32'd3);
        chk("R6 first", 32'(rec[3][0]), 32'(mk(FT_HEAD, 1'b1, 16'h0001)));
        chk("R6 second", 32'(rec[3][1]), 32'(mk(FT_HEAD, 1'b1, 16'h003E)));
        chk("R6 third", 32'(rec[3][2]), 32'(mk(FT_HEAD, 1'b1, 16'h0004)));
    endtask

    task automatic t_lock();
        clear_rec();
        put(0, mk(FT_HEAD, 1'b0, 16'h0041));
        put(0, mk(FT_BODY, 1'b0, 16'h1111));
        put(3, mk(FT_HEAD, 1'b1, 16'h0025));
        wait_cyc(4);
        chk("R5 intruder held", 32'(cnt[1]), 32'd2);
        #5;
        chk("R5 output idle while locked", 32'(out_valid[1]), 32'd0);
        @(negedge clk);
        put(0, mk(FT_TAIL, 1'b0, 16'h2222));
        wait_cyc(4);
        chk("R5 count after tail", 32'(cnt[1]), 32'd4);
        chk("R5 tail before intruder", 32'(rec[1][2]), 32'(mk(FT_TAIL, 1'b0, 16'h2222)));
        chk("R5 intruder after tail", 32'(rec[1][3]), 32'(mk(FT_HEAD, 1'b1, 16'h0009)));
    endtask

    task automatic t_rr();
        logic [FW-1:0] f0;
        clear_rec();
        rdy_o[0] = 1'b0;
        fork
            put(0, mk(FT_HEAD, 1'b1, 16'h0100));
            put(1, mk(FT_HEAD, 1'b1, 16'h0200));
            put(2, mk(FT_HEAD, 1'b1, 16'h0300));
            put(3, mk(FT_HEAD, 1'b1, 16'h0400));
        join
        wait_cyc(1);
        #5;
        f0 = out_flit[0 +: FW];
        chk("R8 valid while stalled", 32'(out_valid[0]), 32'd1);
        @(negedge clk);
        vld[0] = 1'b1;
        fl[0]  = mk(FT_HEAD, 1'b1, 16'h0500);
        wait_cyc(2);
        #5;
        chk("R8 flit stable", 32'(out_flit[0 +: FW]), 32'(f0));
        chk("R8 input backpressure", 32'(in_ready[0]), 32'd0);
        @(negedge clk);
        vld[0] = 1'b0;
        rdy_o[0] = 1'b1;
        wait_cyc(6);
        chk("R8 nothing lost", 32'(cnt[0]), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R7 first round order", 32'(rec[0][k]),
                32'(mk(FT_HEAD, 1'b1, 16'((k + 1) << 8) >> 2)));
        end
        put(2, mk(FT_HEAD, 1'b1, 16'h0300));
        wait_cyc(3);
        clear_rec();
        rdy_o[0] = 1'b0;
        fork
            put(0, mk(FT_HEAD, 1'b1, 16'h0A00));
            put(3, mk(FT_HEAD, 1'b1, 16'h0B00));
        join
        rdy_o[0] = 1'b1;
        wait_cyc(4);
        chk("R7 rotated winner", 32'(rec[0][0]), 32'(mk(FT_HEAD, 1'b1, 16'h02C0)));
        chk("R7 rotated loser", 32'(rec[0][1]), 32'(mk(FT_HEAD, 1'b1, 16'h0280)));
    endtask

    task automatic t_concurrent();
        clear_rec();
        fork
            put(1, mk(FT_HEAD, 1'b0, 16'h0040));
            put(2, mk(FT_HEAD, 1'b0, 16'h0042));
        join
        #5;
        chk("R10 both outputs active", 32'({out_valid[2], out_valid[0]}), 32'h3);
        @(negedge clk);
        fork
            put(1, mk(FT_TAIL, 1'b0, 16'h0D0D));
            put(2, mk(FT_TAIL, 1'b0, 16'h0E0E));
        join
        wait_cyc(3);
        chk("R10 port 0 packet", 32'(cnt[0]), 32'd2);
        chk("R10 port 2 packet", 32'(cnt[2]), 32'd2);
    endtask

    task automatic t_idle();
        clear_rec();
        put(3, mk(FT_IDLE, 1'b0, 16'h0001));
        wait_cyc(4);
        chk("R9 no output", 32'(cnt[0] + cnt[1] + cnt[2] + cnt[3]), 32'd0);
        #5;
        chk("R9 outputs idle", 32'(out_valid), 32'h0);
        chk("R9 buffer still free", 32'(in_ready[3]), 32'd1);
        @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            vld[i]   = 1'b0;
            fl[i]    = '0;
            rdy_o[i] = 1'b1;
        end
        wait_cyc(3);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_single();
        t_lock();
        t_rr();
        t_concurrent();
        t_idle();
        report();
    end

endmodule